// File: doc/BRIEF.md
# Compact 8-bit Smoothing Processor

This block is a small single-cycle 8-bit processor built from two distinct halves. The control path holds a program counter and a program ROM with a fixed machine program. The datapath holds an eight-entry register file, an adder, a signed multiplier that keeps the high byte, and a 256-entry waveform ROM. The program polls a handshake switch. When the switch is high, it reads an index from eight data switches and forms a five-tap smoothed sample around that index. It puts the result on eight LEDs, then waits for the handshake to drop before it polls again.

Register 0 always reads zero, and register 1 is wired to the data switch port. A plain add of those two registers therefore captures the input, so no dedicated input instruction is needed. The kernel weights are immediate bytes inside multiply instructions. A neighbour is fetched by adding a signed immediate offset to the index and using the wrapped sum as the ROM address.

Top module: `smooth_cpu`

## Requirements
- R1: While `rst_sw_n` is low, `led` reads 0 and the program counter sits at the first instruction. After release, execution restarts from that first instruction.
- R2: While `hs_sw` is low in the polling loop, `led` holds its value. After `hs_sw` is first seen high, the new result appears on `led` no sooner than 10 and no later than 20 clock cycles later.
- R3: A multiply forms the signed 16-bit product of two 8-bit two's complement operands and keeps only product bits 15:8.
- R4: Additions are modulo 256, with no saturation and no overflow flag.
- R5: The result for index i is the wrapped sum of five terms. Each term is the upper product byte of W[i+d] times weight c(d), for offsets d = -2, -1, 0, +1, +2 with weights 17, 29, 35, 29, 17.
- R6: The waveform ROM entry k (0..255) equals (3*k*k + 11*k + 7) mod 256, read as a signed byte.
- R7: Neighbour addresses wrap modulo 256. Index 0 uses entries 254, 255, 0, 1, 2, and index 255 uses entries 253, 254, 255, 0, 1.
- R8: The index is taken from `data_sw` once per handshake. Changes on `data_sw` while `hs_sw` stays high, or while it stays low afterwards, leave `led` unchanged until the next rise of `hs_sw`.
- R9: Register 0 reads as zero and ignores writes. Register 1 reads the `data_sw` port. The index is captured by adding the two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_sw_n | input | 1 | Active-low reset switch, asynchronous |
| hs_sw | input | 1 | Handshake switch, polled by the program |
| data_sw | input | 8 | Index switches, readable as register 1 |
| led | output | 8 | Result register driving the LEDs |

## Verification
Two events can land in the same stretch of cycles: a reset arriving mid-computation and a handshake that is still held high. The bench pulls reset low partway through a sample while `hs_sw` stays high. It checks that `led` clears at once. It then releases reset with the handshake still high and expects the program to start over and deliver the correct result for the current switches within the R2 window. A second case changes `data_sw` under a held handshake. The check is that the sample already shown is not disturbed by the new switch value.

// File: rtl/smc_pkg.sv
package smc_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_NOP  = 4'd0,
      OP_ADD  = 4'd1,
      OP_ADDI = 4'd2,
      OP_MUL  = 4'd3,
      OP_MULI = 4'd4,
      OP_LDW  = 4'd5,
      OP_OUT  = 4'd6,
      OP_BHL  = 4'd7,
      OP_BHH  = 4'd8,
      OP_JMP  = 4'd9
   } op_e;

   typedef enum logic [1:0] {
      RES_SUM = 2'd0,
      RES_MUL = 2'd1,
      RES_ROM = 2'd2
   } res_e;

   typedef struct packed {
      logic wr_en;
      logic use_imm;
      res_e res_sel;
      logic out_en;
   } ctl_t;

endpackage

// File: rtl/smc_ctrl.sv
module smc_ctrl
   import smc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int RA_W   = 3,
   parameter int PC_W   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hs,
   output op_e               op,
   output logic [RA_W-1:0]   rd,
   output logic [RA_W-1:0]   rs,
   output logic [RA_W-1:0]   rt,
   output logic [DATA_W-1:0] imm
);

   localparam int INSTR_W = OP_W + 2 * RA_W + DATA_W;
   localparam int IMM_LO  = 0;
   localparam int RS_LO   = DATA_W;
   localparam int RD_LO   = DATA_W + RA_W;
   localparam int OP_LO   = DATA_W + 2 * RA_W;

   logic [PC_W-1:0]    pc;
   logic [PC_W-1:0]    pc_nxt;
   logic [INSTR_W-1:0] instr;
   logic               take;

   function automatic logic [INSTR_W-1:0] mk(op_e o, int d, int s, int v);
      logic [INSTR_W-1:0] w;
      w = '0;
      w[OP_LO +: OP_W]     = o;
      w[RD_LO +: RA_W]     = RA_W'(d);
      w[RS_LO +: RA_W]     = RA_W'(s);
      w[IMM_LO +: DATA_W]  = DATA_W'(v);
      return w;
   endfunction

   // Program store: r2 = index, r3 = fetched/scaled tap, r4 = running sum.
   always_comb begin
      case (pc)
         PC_W'(0):  instr = mk(OP_BHL,  0, 0, 0);
         PC_W'(1):  instr = mk(OP_ADD,  2, 0, 1);
         PC_W'(2):  instr = mk(OP_LDW,  3, 2, -2);
         PC_W'(3):  instr = mk(OP_MULI, 4, 3, 17);
         PC_W'(4):  instr = mk(OP_LDW,  3, 2, -1);
         PC_W'(5):  instr = mk(OP_MULI, 3, 3, 29);
         PC_W'(6):  instr = mk(OP_ADD,  4, 4, 3);
         PC_W'(7):  instr = mk(OP_LDW,  3, 2, 0);
         PC_W'(8):  instr = mk(OP_MULI, 3, 3, 35);
         PC_W'(9):  instr = mk(OP_ADD,  4, 4, 3);
         PC_W'(10): instr = mk(OP_LDW,  3, 2, 1);
         PC_W'(11): instr = mk(OP_MULI, 3, 3, 29);
         PC_W'(12): instr = mk(OP_ADD,  4, 4, 3);
         PC_W'(13): instr = mk(OP_LDW,  3, 2, 2);
         PC_W'(14): instr = mk(OP_MULI, 3, 3, 17);
         PC_W'(15): instr = mk(OP_ADD,  4, 4, 3);
         PC_W'(16): instr = mk(OP_OUT,  0, 4, 0);
         PC_W'(17): instr = mk(OP_BHH,  0, 0, 17);
         PC_W'(18): instr = mk(OP_JMP,  0, 0, 0);
         default:   instr = mk(OP_JMP,  0, 0, 0);
      endcase
   end

   assign op  = op_e'(instr[OP_LO +: OP_W]);
   assign rd  = instr[RD_LO +: RA_W];
   assign rs  = instr[RS_LO +: RA_W];
   assign imm = instr[IMM_LO +: DATA_W];
   assign rt  = imm[RA_W-1:0];

   always_comb begin
      unique case (op)
         OP_BHL:  take = ~hs;
         OP_BHH:  take = hs;
         OP_JMP:  take = 1'b1;
         default: take = 1'b0;
      endcase
      pc_nxt = take ? imm[PC_W-1:0] : pc + PC_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc <= '0;
      else        pc <= pc_nxt;
   end

   assert_pc_home_R1: assert property (@(posedge clk) !rst_n |-> pc == '0)
      else $error("pc not at first instruction during reset");

   assert_poll_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_BHL && !hs) |=> pc == $past(imm[PC_W-1:0]))
      else $error("poll branch did not return to its target");

endmodule

// File: rtl/smc_regfile.sv
module smc_regfile #(
   parameter int DATA_W = 8,
   parameter int REG_N  = 8,
   parameter int RA_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] port_in,
   input  logic [RA_W-1:0]   ra,
   input  logic [RA_W-1:0]   rb,
   input  logic              we,
   input  logic [RA_W-1:0]   wa,
   input  logic [DATA_W-1:0] wd,
   output logic [DATA_W-1:0] qa,
   output logic [DATA_W-1:0] qb
);

   localparam int FIRST_GP = 2;

   logic [DATA_W-1:0] store [FIRST_GP:REG_N-1];

   for (genvar g = FIRST_GP; g < REG_N; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      store[g] <= '0;
         else if (we && wa == RA_W'(g))   store[g] <= wd;
      end
   end

   function automatic logic [DATA_W-1:0] rd_sel(logic [RA_W-1:0] a);
      if (a == RA_W'(0))      return '0;
      else if (a == RA_W'(1)) return port_in;
      else                    return store[a];
   endfunction

   always_comb begin
      qa = rd_sel(ra);
      qb = rd_sel(rb);
   end

   assert_zero_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wa == '0) |=> (qa == '0 || ra != '0))
      else $error("register 0 did not stay zero");

endmodule

// File: rtl/smc_alu.sv
module smc_alu #(
   parameter int DATA_W        = 8,
   parameter bit MUL_SHIFT_ADD = 1'b0
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] sum,
   output logic [DATA_W-1:0] mul_hi
);

   localparam int PROD_W = 2 * DATA_W;

   logic signed [PROD_W-1:0] prod;

   assign sum = a + b;

   if (MUL_SHIFT_ADD) begin : g_shift_add
      always_comb begin
         logic signed [PROD_W-1:0] ax;
         ax   = PROD_W'($signed(a));
         prod = '0;
         for (int j = 0; j < DATA_W; j++) begin
            if (b[j]) begin
               if (j == DATA_W - 1) prod = prod - (ax <<< j);
               else                 prod = prod + (ax <<< j);
            end
         end
      end
   end else begin : g_native
      assign prod = $signed(a) * $signed(b);
   end

   assign mul_hi = prod[PROD_W-1:DATA_W];

   always_comb begin
      if (!a[DATA_W-1] && !b[DATA_W-1])
         assert_mul_sign_R3: assert (mul_hi[DATA_W-1] == 1'b0)
            else $error("positive operands gave negative high byte");
   end

endmodule

// File: rtl/smc_wave_rom.sv
module smc_wave_rom #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] addr,
   output logic [DATA_W-1:0] word
);

   localparam int CALC_W = 3 * DATA_W;

   function automatic logic [DATA_W-1:0] sample(logic [DATA_W-1:0] k);
      logic [CALC_W-1:0] kk;
      logic [CALC_W-1:0] v;
      kk = CALC_W'(k);
      v  = CALC_W'(3) * kk * kk + CALC_W'(11) * kk + CALC_W'(7);
      return v[DATA_W-1:0];
   endfunction

   always_comb word = sample(addr);

endmodule

// File: rtl/smooth_cpu.sv
module smooth_cpu
   import smc_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int REG_N         = 8,
   parameter int PC_W          = 5,
   parameter bit MUL_SHIFT_ADD = 1'b0
) (
   input  logic              clk,
   input  logic              rst_sw_n,
   input  logic              hs_sw,
   input  logic [DATA_W-1:0] data_sw,
   output logic [DATA_W-1:0] led
);

   localparam int RA_W = $clog2(REG_N);

   if (DATA_W != 8) begin : g_bad_width
      $error("program constants assume an 8-bit datapath");
   end
   if (REG_N < 5 || (1 << RA_W) != REG_N) begin : g_bad_regs
      $error("register count must be a power of two, at least 5");
   end
   if (PC_W < 5 || PC_W > DATA_W) begin : g_bad_pc
      $error("program counter width out of range");
   end

   op_e               op;
   logic [RA_W-1:0]   rd, rs, rt;
   logic [DATA_W-1:0] imm;
   logic [DATA_W-1:0] qa, qb, opb, sum, mul_hi, rom_word, wd;
   ctl_t              ctl;

   smc_ctrl #(.DATA_W(DATA_W), .RA_W(RA_W), .PC_W(PC_W)) u_ctrl (
      .clk(clk), .rst_n(rst_sw_n), .hs(hs_sw),
      .op(op), .rd(rd), .rs(rs), .rt(rt), .imm(imm)
   );

   always_comb begin
      ctl = '{wr_en: 1'b0, use_imm: 1'b0, res_sel: RES_SUM, out_en: 1'b0};
      unique case (op)
         OP_ADD:  ctl = '{wr_en: 1'b1, use_imm: 1'b0, res_sel: RES_SUM, out_en: 1'b0};
         OP_ADDI: ctl = '{wr_en: 1'b1, use_imm: 1'b1, res_sel: RES_SUM, out_en: 1'b0};
         OP_MUL:  ctl = '{wr_en: 1'b1, use_imm: 1'b0, res_sel: RES_MUL, out_en: 1'b0};
         OP_MULI: ctl = '{wr_en: 1'b1, use_imm: 1'b1, res_sel: RES_MUL, out_en: 1'b0};
         OP_LDW:  ctl = '{wr_en: 1'b1, use_imm: 1'b1, res_sel: RES_ROM, out_en: 1'b0};
         OP_OUT:  ctl = '{wr_en: 1'b0, use_imm: 1'b0, res_sel: RES_SUM, out_en: 1'b1};
         default: ;
      endcase
   end

   smc_regfile #(.DATA_W(DATA_W), .REG_N(REG_N), .RA_W(RA_W)) u_rf (
      .clk(clk), .rst_n(rst_sw_n), .port_in(data_sw),
      .ra(rs), .rb(rt), .we(ctl.wr_en), .wa(rd), .wd(wd),
      .qa(qa), .qb(qb)
   );

   assign opb = ctl.use_imm ? imm : qb;

   smc_alu #(.DATA_W(DATA_W), .MUL_SHIFT_ADD(MUL_SHIFT_ADD)) u_alu (
      .a(qa), .b(opb), .sum(sum), .mul_hi(mul_hi)
   );

   smc_wave_rom #(.DATA_W(DATA_W)) u_rom (.addr(sum), .word(rom_word));

   always_comb begin
      unique case (ctl.res_sel)
         RES_MUL: wd = mul_hi;
         RES_ROM: wd = rom_word;
         default: wd = sum;
      endcase
   end

   always_ff @(posedge clk or negedge rst_sw_n) begin
      if (!rst_sw_n)       led <= '0;
      else if (ctl.out_en) led <= qa;
   end

   assert_led_only_on_out_R8: assert property (@(posedge clk) disable iff (!rst_sw_n)
      (led != $past(led)) |-> $past(op == OP_OUT))
      else $error("led changed without an output instruction");

endmodule

// File: tb/smooth_cpu_tb.sv
module smooth_cpu_tb;

   logic       clk = 1'b0;
   logic       rst_sw_n;
   logic       hs_sw;
   logic [7:0] data_sw;
   logic [7:0] led;

   int n_run  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   smooth_cpu u_dut (
      .clk(clk), .rst_sw_n(rst_sw_n), .hs_sw(hs_sw),
      .data_sw(data_sw), .led(led)
   );

   localparam int N_VEC = 8;
   localparam int VEC_IDX [N_VEC] = '{2, 10, 77, 100, 127, 128, 200, 253};

   // R6 waveform
   function automatic logic [7:0] wave(int k);
      int v;
      v = (3 * k * k + 11 * k + 7) & 255;
      return 8'(v);
   endfunction

   // R3 / R4 / R5 / R7 expected result
   function automatic logic [7:0] smooth(int i);
      int wts [5] = '{17, 29, 35, 29, 17};
      logic [7:0] acc;
      acc = 8'd0;
      for (int d = 0; d < 5; d++) begin
         int p;
         p   = int'($signed(wave((i + d - 2) & 255))) * wts[d];
         acc = acc + p[15:8];
      end
      return acc;
   endfunction

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: led=%0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cycles(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic run_index(int idx);
      data_sw = 8'(idx);
      hs_sw   = 1'b1;
      cycles(25);
      check("R5", led, smooth(idx));
      hs_sw = 1'b0;
      cycles(4);
   endtask

   initial begin
      logic [7:0] prev;
      rst_sw_n = 1'b0;
      hs_sw    = 1'b0;
      data_sw  = 8'd0;
      cycles(3);
      check("R1 reset state", led, 8'd0);
      rst_sw_n = 1'b1;
      cycles(10);
      check("R2 idle with handshake low", led, 8'd0);

      for (int v = 0; v < N_VEC; v++) run_index(VEC_IDX[v]);

      // R7 wrap at both ends
      data_sw = 8'd0; hs_sw = 1'b1; cycles(25);
      check("R7 index 0", led, smooth(0));
      hs_sw = 1'b0; cycles(4);
      data_sw = 8'd255; hs_sw = 1'b1; cycles(25);
      check("R7 index 255", led, smooth(255));
      hs_sw = 1'b0; cycles(4);

      // R2 latency window
      prev = led;
      data_sw = 8'd40; hs_sw = 1'b1;
      cycles(9);
      check("R2 no early update", led, prev);
      cycles(11);
      check("R2 update by 20 cycles", led, smooth(40));

      // R8 switch changes under held handshake and after release
      data_sw = 8'd150; cycles(20);
      check("R8 held handshake ignores switches", led, smooth(40));
      hs_sw = 1'b0; data_sw = 8'd60; cycles(20);
      check("R8 low handshake keeps result", led, smooth(40));

      // R9 register 1 port read via add to register 0
      hs_sw = 1'b1; cycles(25);
      check("R9 port capture", led, smooth(60));
      hs_sw = 1'b0; cycles(4);

      // R1 reset mid-computation with handshake held
      data_sw = 8'd50; hs_sw = 1'b1; cycles(8);
      rst_sw_n = 1'b0; cycles(2);
      check("R1 reset clears led", led, 8'd0);
      rst_sw_n = 1'b1; cycles(25);
      check("R1 restart after reset", led, smooth(50));
      hs_sw = 1'b0; cycles(4);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule